// File: doc/BRIEF.md
# Multi-Byte Bus Transfer Sequencer

This block takes one processor access of one to ten bytes and carries it out as a series of system-bus cycles. It first obtains the bus from an external arbiter through a request/grant handshake. For each cycle it then drives an address, the byte-lane enables and one command strobe, and holds them until the addressed slave returns a transfer acknowledge. Write bytes come from a byte buffer that is captured when the request is accepted. Read bytes are gathered into a byte buffer that the requester reads once the block reports completion.

The split into bus cycles depends on a width mode input and on the start address. In 16-bit mode, a memory request of two or more bytes that starts at an even address uses double-byte cycles. If the byte count is odd, one final single-byte cycle follows. Every other case uses single-byte cycles on the low lane. The access type selects either the memory command pair or the I/O command pair. I/O addresses always have bit 0 cleared.

Top module: `mbx_seq`

## Requirements
- R1: A request is taken only while `busy` is low and `req_len` is in 1..MAX_BYTES (default 10). A length of 0 or above MAX_BYTES raises no bus request, no strobe and no `done`.
- R2: With `wide_mode`=0, a memory request of N bytes runs exactly N single-byte cycles. Cycle i carries address start+i, has `bus_hi_en_n`=1, and carries its byte on `bus_wdata[7:0]` (writes) or takes it from `bus_rdata[7:0]` (reads).
- R3: With `wide_mode`=1, a memory request with `req_addr[0]`=0 and N>=2 runs double-byte cycles at start, start+2, and so on, with `bus_hi_en_n`=0. The byte at the even address is on bits 7:0 and the next byte is on bits 15:8. For an odd N, the last byte goes in a single-byte cycle on the low lane with `bus_hi_en_n`=1.
- R4: With `wide_mode`=1, a memory request with an odd start address or with N=1 produces the same cycles as in R2.
- R5: Memory requests use `mem_rd`/`mem_wr` and I/O requests (`req_io`=1) use `io_rd`/`io_wr`, chosen by `req_write`. At most one strobe is high at any time.
- R6: I/O requests always use single-byte cycles with `bus_hi_en_n`=1. Cycle i drives address start+i with bit 0 forced to 0.
- R7: A strobe, together with its address, stays high until a clock in which `bus_xack` is high. It is then low for exactly one clock before the next cycle of the same request starts.
- R8: A strobe is high only while `bus_req` and `bus_gnt` are both high. `bus_req` stays high from acceptance until the final acknowledge.
- R9: After a read completes, byte i of `rd_bytes` (bits 8i+7:8i) holds the byte that was transferred for position i. Positions at or beyond N read as zero.
- R10: `done` is a one-clock pulse in the clock after the final acknowledge. `busy` is high from the clock after acceptance until `done` has been given.
- R11: After reset, `busy`, `done`, `bus_req` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a request (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | CNT_W | Byte count, 1..MAX_BYTES |
| wide_mode | input | 1 | 1 = 16-bit bus mode, 0 = 8-bit |
| req_wbytes | input | 8*MAX_BYTES | Write bytes, byte i at bits 8i+7:8i |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| rd_bytes | output | 8*MAX_BYTES | Gathered read bytes |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_addr | output | ADDR_W | Bus address of the current cycle |
| bus_hi_en_n | output | 1 | High byte lane enable, active low |
| bus_wdata | output | 16 | Write data, lanes 15:8 and 7:0 |
| bus_rdata | input | 16 | Read data from the slave |
| bus_xack | input | 1 | Transfer acknowledge from the slave |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |

## Verification
The hardest case to reach is the switch within one request from double-byte to single-byte cycles. This happens in an aligned 16-bit memory access with an odd count, where a lane mistake hides unless the final byte lands at a position the slave pattern tells apart. Directed requests of nine bytes at even addresses, in both directions, force this tail. The random mix then varies start parity, length and mode. The slave model delays each acknowledge by zero to three clocks and the arbiter delays the grant, so strobe holding and the one-clock gap are exercised at varied lengths.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ARB  = 3'd1,
    S_CMD  = 3'd2,
    S_GAP  = 3'd3,
    S_FIN  = 3'd4
  } seq_st_t;

  // a double-byte cycle is allowed only for aligned memory traffic in wide mode
  function automatic logic pair_ok(logic wide, logic io, logic start_odd,
                                   int unsigned left);
    return wide && !io && !start_odd && (left >= 2);
  endfunction

  // byte count covered by one bus cycle
  function automatic int unsigned cycle_bytes(logic pair);
    return pair ? 2 : 1;
  endfunction

endpackage

// File: rtl/mbx_plan.sv
module mbx_plan #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 4
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  len,
  input  logic [CNT_W-1:0]  idx,
  input  logic              wide,
  input  logic              io,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic              pair,
  output logic [CNT_W-1:0]  step,
  output logic              is_last
);
  import mbx_pkg::*;

  logic [CNT_W-1:0]  remain;
  logic [ADDR_W-1:0] raw_addr;

  always_comb begin
    remain   = len - idx;
    raw_addr = base_addr + ADDR_W'(idx);
    pair     = pair_ok(wide, io, base_addr[0], int'(remain));
    step     = CNT_W'(cycle_bytes(pair));
    is_last  = (remain == step);
    if (io) cyc_addr = {raw_addr[ADDR_W-1:1], 1'b0};
    else    cyc_addr = raw_addr;
  end
endmodule

// File: rtl/mbx_lane.sv
module mbx_lane #(
  parameter int MAX_BYTES = 10,
  parameter int CNT_W     = 4
) (
  input  logic [8*MAX_BYTES-1:0] wbuf,
  input  logic [CNT_W-1:0]       idx,
  input  logic                   pair,
  output logic [15:0]            wdata,
  output logic                   hi_en_n
);
  logic [7:0] bytes_a [MAX_BYTES];

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_split
    assign bytes_a[g] = wbuf[8*g +: 8];
  end

  logic [CNT_W-1:0] nxt;
  logic [7:0]       lo_b, hi_b;

  always_comb begin
    nxt  = idx + CNT_W'(1);
    lo_b = 8'h00;
    hi_b = 8'h00;
    for (int k = 0; k < MAX_BYTES; k++) begin
      if (idx == CNT_W'(k)) lo_b = bytes_a[k];
      if (nxt == CNT_W'(k)) hi_b = bytes_a[k];
    end
    wdata   = pair ? {hi_b, lo_b} : {8'h00, lo_b};
    hi_en_n = ~pair;
  end
endmodule

// File: rtl/mbx_gather.sv
module mbx_gather #(
  parameter int MAX_BYTES = 10,
  parameter int CNT_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   cap,
  input  logic [CNT_W-1:0]       idx,
  input  logic                   pair,
  input  logic [15:0]            rdata,
  output logic [8*MAX_BYTES-1:0] rbuf
);
  logic [CNT_W-1:0] nxt;
  assign nxt = idx + CNT_W'(1);

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                b_q <= 8'h00;
      else if (clear)                            b_q <= 8'h00;
      else if (cap && idx == CNT_W'(g))          b_q <= rdata[7:0];
      else if (cap && pair && nxt == CNT_W'(g))  b_q <= rdata[15:8];
    end
    assign rbuf[8*g +: 8] = b_q;
  end
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq #(
  parameter int ADDR_W    = 20,
  parameter int MAX_BYTES = 10,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic                   req_io,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [CNT_W-1:0]       req_len,
  input  logic                   wide_mode,
  input  logic [8*MAX_BYTES-1:0] req_wbytes,
  output logic                   busy,
  output logic                   done,
  output logic [8*MAX_BYTES-1:0] rd_bytes,
  output logic                   bus_req,
  input  logic                   bus_gnt,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic                   bus_hi_en_n,
  output logic [15:0]            bus_wdata,
  input  logic [15:0]            bus_rdata,
  input  logic                   bus_xack,
  output logic                   mem_rd,
  output logic                   mem_wr,
  output logic                   io_rd,
  output logic                   io_wr
);
  import mbx_pkg::*;

  seq_st_t                st;
  logic [ADDR_W-1:0]      base_q;
  logic [CNT_W-1:0]       len_q, idx_q;
  logic                   wr_q, io_q, wide_q;
  logic [8*MAX_BYTES-1:0] wbuf_q;

  // named events used by the checker
  logic accept, strobe, cyc_end, last_end;
  logic pair, is_last;
  logic [CNT_W-1:0] step;

  assign accept = (st == S_IDLE) && req_valid && (req_len != '0) &&
                  (req_len <= CNT_W'(MAX_BYTES));
  assign strobe   = (st == S_CMD);
  assign cyc_end  = strobe && bus_xack;
  assign last_end = cyc_end && is_last;

  mbx_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_plan (
    .base_addr (base_q),
    .len       (len_q),
    .idx       (idx_q),
    .wide      (wide_q),
    .io        (io_q),
    .cyc_addr  (bus_addr),
    .pair      (pair),
    .step      (step),
    .is_last   (is_last)
  );

  mbx_lane #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_lane (
    .wbuf    (wbuf_q),
    .idx     (idx_q),
    .pair    (pair),
    .wdata   (bus_wdata),
    .hi_en_n (bus_hi_en_n)
  );

  mbx_gather #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_gather (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .cap   (cyc_end && !wr_q),
    .idx   (idx_q),
    .pair  (pair),
    .rdata (bus_rdata),
    .rbuf  (rd_bytes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      wr_q   <= 1'b0;
      io_q   <= 1'b0;
      wide_q <= 1'b0;
      wbuf_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          base_q <= req_addr;
          len_q  <= req_len;
          idx_q  <= '0;
          wr_q   <= req_write;
          io_q   <= req_io;
          wide_q <= wide_mode;
          wbuf_q <= req_wbytes;
          st     <= S_ARB;
        end
        S_ARB: if (bus_gnt) st <= S_CMD;
        S_CMD: if (cyc_end) begin
          idx_q <= idx_q + step;
          st    <= is_last ? S_FIN : S_GAP;
        end
        S_GAP:   st <= S_CMD;
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_req = (st == S_ARB) || (st == S_CMD) || (st == S_GAP);
  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign mem_rd  = strobe && !io_q && !wr_q;
  assign mem_wr  = strobe && !io_q &&  wr_q;
  assign io_rd   = strobe &&  io_q && !wr_q;
  assign io_wr   = strobe &&  io_q &&  wr_q;
endmodule

// File: rtl/mbx_seq_chk.sv
module mbx_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              io_rd,
  input logic              io_wr,
  input logic              bus_xack,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_hi_en_n,
  input logic              done,
  input logic              cyc_end,
  input logic              last_end
);
  logic [3:0] vec;
  logic       any_s;
  assign vec   = {mem_rd, mem_wr, io_rd, io_wr};
  assign any_s = |vec;

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec));

  a_r8_strobe_granted: assert property (@(posedge clk) disable iff (!rst_n)
    any_s |-> (bus_req && bus_gnt));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (any_s && !bus_xack) |=> (vec == $past(vec)) && $stable(bus_addr));

  a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !any_s);

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !last_end) |=> bus_req);

  a_r6_io_even: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |-> (!bus_addr[0] && bus_hi_en_n));

  a_r3_pair_even: assert property (@(posedge clk) disable iff (!rst_n)
    (any_s && !bus_hi_en_n) |-> !bus_addr[0]);

  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_end |=> done);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind mbx_seq mbx_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .bus_xack    (bus_xack),
  .bus_req     (bus_req),
  .bus_gnt     (bus_gnt),
  .bus_addr    (bus_addr),
  .bus_hi_en_n (bus_hi_en_n),
  .done        (done),
  .cyc_end     (cyc_end),
  .last_end    (last_end)
);

// File: tb/sim_mbx_seq.sv
`timescale 1ns/1ps
module sim_mbx_seq;
  localparam int AW = 20;
  localparam int MB = 10;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, wide_mode = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_len = '0;
  logic [8*MB-1:0] req_wbytes = '0;
  logic          busy, done;
  logic [8*MB-1:0] rd_bytes;
  logic          bus_req, bus_hi_en_n;
  logic          bus_gnt = 1'b0, bus_xack = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata;
  logic [15:0]   bus_rdata = '0;
  logic          mem_rd, mem_wr, io_rd, io_wr;

  always #4 clk = ~clk;

  mbx_seq #(.ADDR_W(AW), .MAX_BYTES(MB)) u0 (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // expected cycle list for the running request
  logic [AW-1:0] e_addr [MB];
  logic          e_pair [MB];
  logic [15:0]   e_wd   [MB];
  logic [3:0]    e_vec;
  string         e_tag;
  logic          e_wr;
  int            e_n = 0;
  int            cyc_i = 0;
  int            req_seen = 0;

  function automatic logic [7:0] pat(logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A ^ {a[11:8], 4'h3};
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // arbiter model
  initial begin
    int gd = 0;
    forever begin
      @(negedge clk);
      if (bus_req) req_seen++;
      if (!bus_req) begin bus_gnt = 1'b0; gd = $urandom_range(0, 2); end
      else if (!bus_gnt) begin
        if (gd == 0) bus_gnt = 1'b1; else gd--;
      end
    end
  end

  // slave model
  initial begin
    int wt = 0;
    forever begin
      @(negedge clk);
      if (bus_xack) begin
        bus_xack = 1'b0;
        wt = $urandom_range(0, 3);
        chk(!(mem_rd | mem_wr | io_rd | io_wr), "R7", "strobe one clock after ack", 1, 0);
      end else if (mem_rd | mem_wr | io_rd | io_wr) begin
        if (wt > 0) wt--;
        else begin
          if (cyc_i >= e_n) begin
            chk(0, e_tag, "extra bus cycle", cyc_i, e_n);
          end else begin
            chk(bus_addr == e_addr[cyc_i], e_tag, "cycle address", bus_addr, e_addr[cyc_i]);
            chk(bus_hi_en_n == !e_pair[cyc_i], e_tag, "high lane enable", bus_hi_en_n, !e_pair[cyc_i]);
            chk({mem_rd, mem_wr, io_rd, io_wr} == e_vec, "R5", "command strobe",
                {mem_rd, mem_wr, io_rd, io_wr}, e_vec);
            if (e_wr) begin
              if (e_pair[cyc_i])
                chk(bus_wdata == e_wd[cyc_i], e_tag, "write lanes", bus_wdata, e_wd[cyc_i]);
              else
                chk(bus_wdata[7:0] == e_wd[cyc_i][7:0], e_tag, "write low lane",
                    bus_wdata[7:0], e_wd[cyc_i][7:0]);
            end
          end
          bus_rdata = {bus_hi_en_n ? 8'hEE : pat(bus_addr | AW'(1)), pat(bus_addr)};
          bus_xack = 1'b1;
          cyc_i++;
        end
      end
    end
  end

  task automatic run_req(logic [AW-1:0] a, int len, bit wide, bit io, bit wr);
    logic [8*MB-1:0] wb;
    logic [8*MB-1:0] exp_rb;
    int  k, dn, waitc;
    bit  valid;
    for (int i = 0; i < MB; i++) wb[8*i +: 8] = 8'($urandom);
    valid = (len >= 1) && (len <= MB);
    e_wr  = wr;
    e_vec = io ? (wr ? 4'b0001 : 4'b0010) : (wr ? 4'b0100 : 4'b1000);
    if (io) e_tag = "R6";
    else if (wide && !a[0] && len > 1) e_tag = "R3";
    else if (wide) e_tag = "R4";
    else e_tag = "R2";
    // expected cycle list
    e_n = 0; k = 0; exp_rb = '0;
    while (valid && k < len) begin
      logic [AW-1:0] ca;
      bit two;
      two = wide && !io && (a[0] == 1'b0) && (len - k >= 2);
      ca = a + AW'(k);
      if (io) ca[0] = 1'b0;
      e_addr[e_n] = ca;
      e_pair[e_n] = two;
      e_wd[e_n]   = {two ? wb[8*(k+1) +: 8] : 8'h00, wb[8*k +: 8]};
      exp_rb[8*k +: 8] = pat(ca);
      if (two) exp_rb[8*(k+1) +: 8] = pat(ca + AW'(1));
      k += two ? 2 : 1;
      e_n++;
    end
    cyc_i = 0; req_seen = 0;
    @(negedge clk);
    req_addr = a; req_len = CW'(len); wide_mode = wide; req_io = io;
    req_write = wr; req_wbytes = wb; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (valid) chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
    dn = 0; waitc = 0;
    while (dn == 0 && waitc < (valid ? 200 : 20)) begin
      if (done) dn++;
      @(negedge clk);
      waitc++;
    end
    repeat (3) begin
      if (done) dn++;
      @(negedge clk);
    end
    if (valid) begin
      chk(dn == 1, "R10", "done pulses", dn, 1);
      chk(cyc_i == e_n, e_tag, "cycle count", cyc_i, e_n);
      chk(busy == 1'b0, "R10", "busy after done", busy, 0);
      if (!wr) chk(rd_bytes == exp_rb, "R9", "read buffer", rd_bytes, exp_rb);
    end else begin
      chk(dn == 0 && req_seen == 0 && cyc_i == 0, "R1", "bad length activity",
          dn + req_seen + cyc_i, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0432));
    repeat (3) @(negedge clk);
    chk({busy, done, bus_req, mem_rd, mem_wr, io_rd, io_wr} == 7'b0, "R11", "reset outputs",
        {busy, done, bus_req, mem_rd, mem_wr, io_rd, io_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, bus_req} == 3'b0, "R11", "idle after reset", {busy, done, bus_req}, 0);
    run_req(20'h01000, 10, 0, 0, 0);   // R2 read
    run_req(20'h01233, 7,  0, 0, 1);   // R2 write
    run_req(20'h02000, 10, 1, 0, 1);   // R3 even
    run_req(20'h02100, 9,  1, 0, 0);   // R3 odd tail read
    run_req(20'h02200, 9,  1, 0, 1);   // R3 odd tail write
    run_req(20'h03001, 4,  1, 0, 1);   // R4 odd start
    run_req(20'h03002, 1,  1, 0, 0);   // R4 single byte
    run_req(20'h00041, 5,  1, 1, 0);   // R6 io read
    run_req(20'h00080, 3,  0, 1, 1);   // R6 io write
    run_req(20'h04000, 0,  1, 0, 0);   // R1 zero length
    run_req(20'h04000, 11, 1, 0, 1);   // R1 too long
    run_req(20'h04000, 15, 0, 1, 0);   // R1 too long
    for (int t = 0; t < 80; t++)
      run_req(AW'($urandom), $urandom_range(1, MB), 1'($urandom), 1'($urandom), 1'($urandom));
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule